// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer, 9 bits wide and 1024 words deep, whose producer and consumer run on unrelated clocks. The producer pushes words through a valid/ready handshake on the write clock. The consumer asks for words with a request strobe on the read clock and receives each one, with a valid pulse, one read-clock cycle later.

Four active-low status outputs describe how full the buffer is: empty, almost-empty, almost-full and full. The full pair is registered on the write clock, and the empty pair on the read clock. The two almost thresholds come from two 10-bit offset registers. Both registers return to 7 at reset and can be reloaded through a strobe-and-select port on the write clock. Pointers pass between the clock domains as Gray code through two-stage synchronizers. Each side therefore sees the other side's progress a few cycles late, so its flags can assert early but never late.

Back-pressure rules: a word is taken on a write-clock edge where `in_valid` and `in_ready` are both high, and `in_valid` with `in_ready` low has no effect. A read request is accepted on a read-clock edge only while `empty_n` is high. A request made while `empty_n` is low is dropped, and no data pulse follows it. The consumer cannot stall `out_data`, so it must take the word in the cycle that `out_valid` is high.

Top module: `flagged_async_fifo`

## Requirements
- R1: After reset, `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, and both offset registers hold 7.
- R2: Words leave in the order they were accepted. `out_valid` pulses high on the read-clock edge that follows each accepted request, carrying the oldest stored word on `out_data`.
- R3: A write is accepted only when `in_valid` and `in_ready` are both high. `in_ready` equals `full_n`, so a word offered while full is discarded and overwrites nothing.
- R4: A request made while `empty_n` is low produces no `out_valid` pulse and does not advance the read position.
- R5: `empty_n` is low when the read side counts 0 stored words and high otherwise.
- R6: `aempty_n` is low while the read side counts 0 to n words and high at n+1 or more, where n is the empty offset. With no reads after reset, it rises once the (n+1)th write has reached the read side.
- R7: `afull_n` is low while the write side counts DEPTH-m words or more and high at DEPTH-(m+1) or fewer, where m is the full offset. With no reads after reset, it falls on the write-clock edge of the (DEPTH-m)th write.
- R8: `full_n` is low only while the write side counts exactly DEPTH words, and it falls on the edge of the DEPTH-th write.
- R9: When `cfg_load` is high on a write-clock edge, `cfg_value` is stored in the empty offset if `cfg_sel` is 0, or in the full offset if `cfg_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Buffer can take a word (not full) |
| in_data | input | 9 | Word offered by the producer |
| out_req | input | 1 | Consumer asks for the next word |
| out_valid | output | 1 | `out_data` holds a word this cycle |
| out_data | output | 9 | Word returned to the consumer |
| full_n | output | 1 | Low when full, write clock |
| afull_n | output | 1 | Low when at or above DEPTH-m, write clock |
| empty_n | output | 1 | Low when empty, read clock |
| aempty_n | output | 1 | Low when at or below n, read clock |
| cfg_load | input | 1 | Offset load strobe, write clock |
| cfg_sel | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| cfg_value | input | 10 | Offset value to load |

## Verification
The hardest states to reach are the exact thresholds at the top of the buffer. These are the edge where the almost-full flag falls after DEPTH-m writes, and the edge where the full flag falls on the last free slot followed by a rejected write. The stimulus reaches them with no reads outstanding, which keeps the stale synchronized read pointer equal to the true one. It fills the buffer one word at a time and checks both flags on the write edge just before and just after each threshold. It then loads new offsets and repeats the walk at both thresholds. On the read side, the bench allows for the pointer-crossing delay by waiting several read cycles before it checks the almost-empty flag at n and at n+1 words.

// File: rtl/fafifo_pkg.sv
package fafifo_pkg;
  localparam int unsigned OFS_RESET = 7;
  typedef enum logic {
    SEL_EMPTY_OFS = 1'b0,
    SEL_FULL_OFS  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/fafifo_sync.sv
module fafifo_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fafifo_mem.sv
module fafifo_mem #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fafifo_wr_ctrl.sv
module fafifo_wr_ctrl #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned OW    = 10,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] rgray_sync,
  input  logic [OW-1:0] full_ofs,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          afull_n
);
  logic [PW-1:0] wbin, wbin_nxt, rbin_s, cnt_nxt;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign we       = in_valid && full_n;
  assign waddr    = wbin[AW-1:0];
  assign wbin_nxt = wbin + PW'(we);
  assign rbin_s   = g2b(rgray_sync);
  assign cnt_nxt  = wbin_nxt - rbin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= wbin_nxt ^ (wbin_nxt >> 1);
      full_n  <= (cnt_nxt != PW'(DEPTH));
      afull_n <= (cnt_nxt < (PW'(DEPTH) - PW'(full_ofs)));
    end
  end

  // R3: the write-side count can never exceed the depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin - rbin_s) <= PW'(DEPTH));
  // R8: full is always also almost full
  assert_full_implies_afull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
endmodule

// File: rtl/fafifo_rd_ctrl.sv
module fafifo_rd_ctrl #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned OW    = 10,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_req,
  input  logic [PW-1:0] wgray_sync,
  input  logic [OW-1:0] empty_ofs,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          out_valid,
  output logic          empty_n,
  output logic          aempty_n
);
  logic [PW-1:0] rbin, rbin_nxt, wbin_s, cnt_nxt;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign re       = out_req && empty_n;
  assign raddr    = rbin[AW-1:0];
  assign rbin_nxt = rbin + PW'(re);
  assign wbin_s   = g2b(wgray_sync);
  assign cnt_nxt  = wbin_s - rbin_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
      empty_n   <= 1'b0;
      aempty_n  <= 1'b0;
    end else begin
      rbin      <= rbin_nxt;
      rgray     <= rbin_nxt ^ (rbin_nxt >> 1);
      out_valid <= re;
      empty_n   <= (cnt_nxt != '0);
      aempty_n  <= (cnt_nxt > PW'(empty_ofs));
    end
  end

  // R4: the read side never counts more than it could have seen written
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin_s - rbin) <= PW'(DEPTH));
  // R2: every data pulse answers an accepted request one cycle earlier
  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_req && empty_n));
  // R6: empty always implies almost empty
  assert_empty_implies_aempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

// File: rtl/flagged_async_fifo.sv
module flagged_async_fifo
  import fafifo_pkg::*;
#(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned OW    = 10,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          out_req,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n,
  input  logic          cfg_load,
  input  logic          cfg_sel,
  input  logic [OW-1:0] cfg_value
);
  logic [OW-1:0] empty_ofs_w, empty_ofs_r, full_ofs;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          we, re;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_ofs_w <= OW'(OFS_RESET);
      full_ofs    <= OW'(OFS_RESET);
    end else if (cfg_load) begin
      if (ofs_sel_e'(cfg_sel) == SEL_FULL_OFS) full_ofs <= cfg_value;
      else                                      empty_ofs_w <= cfg_value;
    end
  end

  // R9: a load lands in the selected register only
  assert_cfg_select_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (cfg_load && cfg_sel) |=> $stable(empty_ofs_w));

  // empty offset is quasi-static; resampled into the read domain
  fafifo_sync #(.W(OW)) u_ofs_sync (
    .clk(rd_clk), .rst_n(rst_n), .d(empty_ofs_w), .q(empty_ofs_r));
  fafifo_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  fafifo_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  fafifo_wr_ctrl #(.DEPTH(DEPTH), .OW(OW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .in_valid(in_valid), .rgray_sync(rgray_s),
    .full_ofs(full_ofs), .we(we), .waddr(waddr), .wgray(wgray),
    .full_n(full_n), .afull_n(afull_n));

  fafifo_rd_ctrl #(.DEPTH(DEPTH), .OW(OW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .out_req(out_req), .wgray_sync(wgray_s),
    .empty_ofs(empty_ofs_r), .re(re), .raddr(raddr), .rgray(rgray),
    .out_valid(out_valid), .empty_n(empty_n), .aempty_n(aempty_n));

  fafifo_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(in_data),
    .rd_clk(rd_clk), .re(re), .raddr(raddr), .rdata(out_data));

  assign in_ready = full_n;
endmodule

// File: tb/flagged_async_fifo_test.sv
module flagged_async_fifo_test;
  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, out_req = 1'b0, cfg_load = 1'b0, cfg_sel = 1'b0;
  logic [8:0] in_data = '0;
  logic [9:0] cfg_value = '0;
  logic       in_ready, out_valid, full_n, afull_n, empty_n, aempty_n;
  logic [8:0] out_data;

  int checks = 0, errors = 0, wcount = 0, seed = 5;
  bit done = 1'b0;
  logic [8:0] sb[$];

  always #4 wr_clk = ~wr_clk;   // 125 MHz
  always #5.5 rd_clk = ~rd_clk;

  flagged_async_fifo uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_req(out_req), .out_valid(out_valid), .out_data(out_data),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_value(cfg_value));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: offer one word; expected items go to the scoreboard
  task automatic push(output bit acc);
    logic [8:0] d;
    d = 9'((seed * 37 + 11) & 9'h1FF);
    seed++;
    @(negedge wr_clk);
    in_valid = 1'b1;
    in_data  = d;
    acc      = in_ready;
    @(posedge wr_clk);
    #1 in_valid = 1'b0;
    if (acc) begin
      sb.push_back(d);
      wcount++;
    end
  endtask

  task automatic push_n(input int n);
    bit a;
    for (int i = 0; i < n; i++) push(a);
  endtask

  task automatic pop(output bit acc);
    @(negedge rd_clk);
    out_req = 1'b1;
    acc     = empty_n;
    @(posedge rd_clk);
    #1 out_req = 1'b0;
    if (acc) wcount--;
  endtask

  task automatic drain();
    bit a;
    a = 1'b1;
    while (a) pop(a);
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic load_cfg(input logic sel, input logic [9:0] v);
    @(negedge wr_clk);
    cfg_load = 1'b1; cfg_sel = sel; cfg_value = v;
    @(negedge wr_clk);
    cfg_load = 1'b0;
  endtask

  // monitor: compare each delivered word with the scoreboard head (R2)
  always @(negedge rd_clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2: actual word %0h expected none", out_data);
      end else begin
        logic [8:0] e;
        e = sb.pop_front();
        if (out_data !== e) begin
          errors++;
          $display("FAIL R2: actual %0h expected %0h", out_data, e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    #20 rst_n = 1'b1;
    settle();
    chk("R1 empty_n", empty_n, 0);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 afull_n", afull_n, 1);

    // default empty offset 7
    push_n(7); settle();
    chk("R5 empty_n with 7", empty_n, 1);
    chk("R6 aempty_n at n=7", aempty_n, 0);
    push_n(1); settle();
    chk("R6 aempty_n at n+1", aempty_n, 1);
    chk("R7 afull_n low count", afull_n, 1);
    drain();
    chk("R5 empty_n drained", empty_n, 0);
    chk("R6 aempty_n drained", aempty_n, 0);

    // request while empty is dropped
    pop(a);
    chk("R4 request accepted", a, 0);
    @(negedge rd_clk);
    chk("R4 no out_valid", out_valid, 0);
    chk("R4 scoreboard untouched", sb.size(), 0);
    settle();

    // default full offset 7: almost-full at 1017 words
    push_n(1016);
    @(negedge wr_clk);
    chk("R7 afull_n at DEPTH-8", afull_n, 1);
    push_n(1);
    @(negedge wr_clk);
    chk("R7 afull_n at DEPTH-7", afull_n, 0);
    push_n(6);
    @(negedge wr_clk);
    chk("R8 full_n at DEPTH-1", full_n, 1);
    push_n(1);
    @(negedge wr_clk);
    chk("R8 full_n at DEPTH", full_n, 0);
    chk("R3 in_ready when full", in_ready, 0);
    push(a);
    chk("R3 write while full", a, 0);
    chk("R3 stored count", wcount, 1024);
    drain();
    chk("R2 all words delivered", sb.size(), 0);
    settle();

    // reload offsets: empty 3, full 100
    load_cfg(1'b0, 10'd3);
    load_cfg(1'b1, 10'd100);
    settle();
    push_n(3); settle();
    chk("R9 aempty_n at new n=3", aempty_n, 0);
    push_n(1); settle();
    chk("R9 aempty_n at new n+1", aempty_n, 1);
    push_n(919);
    @(negedge wr_clk);
    chk("R9 afull_n at DEPTH-101", afull_n, 1);
    push_n(1);
    @(negedge wr_clk);
    chk("R9 afull_n at DEPTH-100", afull_n, 0);
    chk("R8 full_n below DEPTH", full_n, 1);
    drain();
    chk("R2 second pass delivered", sb.size(), 0);
    chk("R5 empty at end", empty_n, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule